// File: doc/BRIEF.md
# Three-Product Split Multiplier

This block multiplies two unsigned operands of `W` bits and returns the exact `2W`-bit product. It uses one level of divide-and-conquer. Each operand is cut into an upper and a lower half. Only three half-size products are formed:

- the product of the upper halves;
- the product of the lower halves;
- the product of the two half-sums, each sum one bit wider than a half.

The cross term is not computed directly. It comes from the half-sum product, minus the other two products. The three pieces are then shifted into place and summed.

When `W` is odd, each operand is zero-extended at its most significant end to the next even width. Both halves are then equal in size, and the value of the operand does not change. A parameter selects the output timing. In one mode the product is purely combinational. In the other, a single output register holds the product with one clock of latency and clears on reset. The block is meant as an arithmetic core inside wider datapaths. Examples are accumulate loops and filter taps that need a full-precision product of wide operands.

Top module: `kmul_top`

## Requirements
- R1: `p_o` equals the unsigned product of `a_i` and `b_i`, exact over all `2W` bits, for every operand pair.
- R2: With `REG_OUT=1`, `p_o` changes only at a rising edge of `clk_i`. It then shows the product of the operands present just before that edge. Operand changes between edges leave `p_o` unchanged.
- R3: With `REG_OUT=1`, driving `rst_ni` low forces `p_o` to zero at once, whatever the operands are. `p_o` stays zero while `rst_ni` is low.
- R4: When both operands are all ones, the result is (2^W−1)^2. Read from the MSB, that is W−1 ones, then W zeros, then a single one. This is the case that maximises the half-sum product.
- R5: An odd `W` is zero-padded at the MSB to an even split and still gives exact products. This is checked over every operand pair at `W=7` in combinational mode (`REG_OUT=0`).
- R6: If either operand is zero, the product is zero.
- R7: The half-sum product is never less than the sum of the upper-half and lower-half products. As a result, the recovered cross term never wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset of the output register |
| a_i | input | W | Unsigned multiplicand |
| b_i | input | W | Unsigned multiplier |
| p_o | output | 2W | Unsigned product, registered when `REG_OUT=1` |

## Verification
The bench goes after the all-ones operands. There the half-sums carry into their extra bit and the middle product reaches its largest value. A design that sized the sums or the recovered cross term one bit too narrow would drop a carry and return a product that is short by a power of two. A single zero operand is tested to catch a cross term that does not cancel, which would leave stray upper bits. Odd widths are covered exhaustively: padding on the wrong side would scale every product by a power of two. The register timing is probed between edges and under a reset asserted mid-run. These checks expose an output that follows the inputs combinationally, or a reset that waits for a clock.

// File: rtl/kmul_pkg.sv
package kmul_pkg;
  // half width after padding an odd operand up to an even one
  function automatic int half_w(int w);
    return (w + 1) / 2;
  endfunction
endpackage

// File: rtl/kmul_split.sv
module kmul_split import kmul_pkg::*; #(
  parameter int W = 16
) (
  input  logic [W-1:0]          op_i,
  output logic [half_w(W)-1:0]  hi_o,
  output logic [half_w(W)-1:0]  lo_o,
  output logic [half_w(W):0]    sum_o
);
  localparam int H  = half_w(W);
  localparam int PW = 2 * H;
  localparam int SW = H + 1;

  logic [PW-1:0] pad;

  // zero-extend at the MSB so the value is preserved
  assign pad   = PW'(op_i);
  assign hi_o  = pad[PW-1:H];
  assign lo_o  = pad[H-1:0];
  assign sum_o = SW'(hi_o) + SW'(lo_o);
endmodule

// File: rtl/kmul_core.sv
module kmul_core #(
  parameter int AW = 8
) (
  input  logic [AW-1:0]   a_i,
  input  logic [AW-1:0]   b_i,
  output logic [2*AW-1:0] p_o
);
  localparam int PW = 2 * AW;

  assign p_o = PW'(a_i) * PW'(b_i);
endmodule

// File: rtl/kmul_combine.sv
module kmul_combine #(
  parameter int H  = 8,
  parameter int OW = 32
) (
  input  logic [2*H-1:0] z2_i,
  input  logic [2*H-1:0] z0_i,
  input  logic [2*H+1:0] zm_i,
  output logic [OW-1:0]  p_o
);
  localparam int ZW = 2 * H + 2;
  localparam int RW = 4 * H;

  logic [ZW-1:0] z1;
  logic [RW-1:0] acc;

  // cross term = (xh+xl)(yh+yl) - xh*yh - xl*yl, never negative
  assign z1  = zm_i - ZW'(z2_i) - ZW'(z0_i);
  assign acc = (RW'(z2_i) << (2 * H)) + (RW'(z1) << H) + RW'(z0_i);

  generate
    if (OW == RW) begin : g_full
      assign p_o = acc;
    end else begin : g_trim
      // padded upper bits are always zero for an odd width
      assign p_o = acc[OW-1:0];
    end
  endgenerate
endmodule

// File: rtl/kmul_top.sv
module kmul_top import kmul_pkg::*; #(
  parameter int W       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  localparam int H  = half_w(W);
  localparam int MW = H + 1;
  localparam int OW = 2 * W;

  logic [H-1:0]      ah, al, bh, bl;
  logic [MW-1:0]     as_w, bs_w;
  logic [2*H-1:0]    z2_w, z0_w;
  logic [2*MW-1:0]   zm_w;
  logic [OW-1:0]     prod_w;

  kmul_split #(.W(W)) u_split_a (.op_i(a_i), .hi_o(ah), .lo_o(al), .sum_o(as_w));
  kmul_split #(.W(W)) u_split_b (.op_i(b_i), .hi_o(bh), .lo_o(bl), .sum_o(bs_w));

  kmul_core #(.AW(H))  u_mul_hi  (.a_i(ah),   .b_i(bh),   .p_o(z2_w));
  kmul_core #(.AW(H))  u_mul_lo  (.a_i(al),   .b_i(bl),   .p_o(z0_w));
  kmul_core #(.AW(MW)) u_mul_mid (.a_i(as_w), .b_i(bs_w), .p_o(zm_w));

  kmul_combine #(.H(H), .OW(OW)) u_combine (
    .z2_i(z2_w),
    .z0_i(z0_w),
    .zm_i(zm_w),
    .p_o (prod_w)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) p_o <= '0;
        else         p_o <= prod_w;
      end
    end else begin : g_comb
      assign p_o = prod_w;
    end
  endgenerate
endmodule

// File: rtl/kmul_chk.sv
module kmul_chk import kmul_pkg::*; #(
  parameter int W       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [W-1:0]            a_i,
  input logic [W-1:0]            b_i,
  input logic [2*W-1:0]          p_o,
  input logic [2*half_w(W)-1:0]  z2_i,
  input logic [2*half_w(W)-1:0]  z0_i,
  input logic [2*half_w(W)+1:0]  zm_i
);
  localparam int H  = half_w(W);
  localparam int ZW = 2 * H + 2;
  localparam int OW = 2 * W;
  localparam logic [OW-1:0] MAX_SQ = {{(W-1){1'b1}}, {W{1'b0}}, 1'b1};

  logic [OW-1:0] ref_prod;
  logic          primed;

  assign ref_prod = OW'(a_i) * OW'(b_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed <= 1'b0;
    else         primed <= 1'b1;
  end

  // R7
  mid_no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zm_i >= (ZW'(z2_i) + ZW'(z0_i)));

  generate
    if (REG_OUT) begin : g_reg
      // R1 R2
      product_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        primed |-> p_o == $past(ref_prod));
      // R3
      reset_clear_chk: assert property (@(posedge clk_i)
        !rst_ni |-> p_o == '0);
      // R4
      all_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        primed && $past(&a_i && &b_i) |-> p_o == MAX_SQ);
      // R6
      zero_operand_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        primed && $past(a_i == '0 || b_i == '0) |-> p_o == '0);
    end else begin : g_comb
      // R1 R5
      product_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        p_o == ref_prod);
      // R4
      all_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (&a_i && &b_i) |-> p_o == MAX_SQ);
      // R6
      zero_operand_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (a_i == '0 || b_i == '0) |-> p_o == '0);
    end
  endgenerate
endmodule

bind kmul_top kmul_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .a_i   (a_i),
  .b_i   (b_i),
  .p_o   (p_o),
  .z2_i  (z2_w),
  .z0_i  (z0_w),
  .zm_i  (zm_w)
);

// File: tb/kmul_top_test.sv
module kmul_top_test;
  localparam int W  = 16;
  localparam int OW = 2 * W;
  localparam int WO = 7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_ni;
  logic [W-1:0]      a_i, b_i;
  logic [OW-1:0]     p_o;
  logic [WO-1:0]     oa, ob;
  logic [2*WO-1:0]   op;

  kmul_top #(.W(W), .REG_OUT(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .p_o(p_o));

  kmul_top #(.W(WO), .REG_OUT(1'b0)) uut_odd (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(oa), .b_i(ob), .p_o(op));

  typedef struct {
    logic [63:0] exp;
    string       req;
  } item_t;

  item_t       sb_q[$];
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;
  logic [63:0] last_exp = '0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(logic [W-1:0] a, logic [W-1:0] b, string req);
    item_t it;
    @(negedge clk);
    a_i = a;
    b_i = b;
    it.exp = 64'(a) * 64'(b);
    it.req = req;
    last_exp = it.exp;
    sb_q.push_back(it);
  endtask

  // monitor: registered output settles after the edge
  always @(posedge clk) begin
    item_t it;
    #2;
    if (rst_ni && sb_q.size() > 0) begin
      it = sb_q.pop_front();
      check(it.req, 64'(p_o), it.exp);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    a_i = '1;
    b_i = 16'd3;
    oa = '0;
    ob = '0;
    repeat (3) @(negedge clk);
    check("R3 reset holds zero", 64'(p_o), 64'd0);
    rst_ni = 1'b1;

    drive(16'h0000, 16'hBEEF, "R6 a zero");
    drive(16'h1234, 16'h0000, "R6 b zero");
    drive(16'hFFFF, 16'hFFFF, "R4 all ones");
    drive(16'hFFFF, 16'h0001, "R1 identity");
    drive(16'h8000, 16'h8000, "R1 top bits");
    drive(16'h00FF, 16'hFF00, "R1 split halves");
    drive(16'hFF00, 16'h00FF, "R1 split swapped");
    drive(16'h0100, 16'h0100, "R1 half boundary");
    for (int i = 0; i < 40; i++) drive(W'($urandom), W'($urandom), "R1 random");
    repeat (3) @(negedge clk);

    // R2: between edges the output holds the previous product
    a_i = 16'd3;
    b_i = 16'd5;
    #1 check("R2 hold between edges", 64'(p_o), last_exp);
    @(posedge clk);
    #2 check("R2 update at edge", 64'(p_o), 64'd15);

    // R3: asynchronous clear mid-run
    @(negedge clk);
    a_i = 16'hFFFF;
    b_i = 16'hFFFF;
    rst_ni = 1'b0;
    #1 check("R3 async clear", 64'(p_o), 64'd0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R5: exhaustive odd-width sweep, combinational
    for (int x = 0; x < (1 << WO); x++) begin
      for (int y = 0; y < (1 << WO); y++) begin
        oa = WO'(x);
        ob = WO'(y);
        #1 check("R5 odd width", 64'(op), 64'(x * y));
      end
    end

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule